// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two levels of page table from a word-addressed memory. A request carries a virtual address and an access kind: read, write or execute. The walker first reads a directory entry. The directory table sits in the page frame named by the `root_frame` input, and the entry is picked by the top ten address bits. That entry names the frame that holds the leaf table, and the middle ten address bits pick the leaf entry there. The leaf entry's frame number, joined with the twelve-bit page offset, forms the physical address.

Before the walker answers, it checks that both entries are valid and that the leaf grants the requested kind of access. It then keeps the leaf's usage bits up to date in hardware. A successful access marks the leaf as referenced, and a successful write also marks it as modified. The leaf is written back to memory only when one of those bits actually changes. The walker takes one translation at a time and holds its request port not-ready until the response pulse has been given.

Top module: `ptw_top`

## Requirements
- R1: The directory entry is read from word address {root_frame, vaddr[31:22]}.
- R2: When the directory entry is valid, the leaf entry is read from word address {directory frame field, vaddr[21:12]}. An entry has valid at bit 0, read at bit 1, write at bit 2, execute at bit 3, referenced at bit 4, modified at bit 5, and the frame number at bits [31:12].
- R3: A successful translation responds with fault code 0 and rsp_paddr = {leaf frame field, vaddr[11:0]}. A faulting response drives rsp_paddr to zero.
- R4: A directory entry with valid 0 gives fault code 1 after exactly one memory read. No leaf read and no write follow.
- R5: A leaf entry with valid 0 gives fault code 2 (page not present). The leaf is not written back.
- R6: The access kind is coded 0 read, 1 write, 2 execute and 3 reserved. A kind whose leaf permission bit is 0 gives fault code 3 (protection), and code 3 is always refused. The leaf in memory is left unchanged.
- R7: A successful access sets the referenced bit in memory. The leaf is written back only if that changes the entry.
- R8: A successful write also sets the modified bit. Reads and executes never set it.
- R9: rsp_valid is a single-cycle pulse. When a write-back is needed, the pulse comes after the write-back has been acknowledged.
- R10: req_ready is high when idle and low from the accepting cycle through the response cycle.
- R11: A memory request holds mem_req, mem_we, mem_addr and mem_wdata steady until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| root_frame | input | 20 | Frame holding the directory table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 2 | 0 ok, 1 directory invalid, 2 page absent, 3 protection |
| rsp_paddr | output | 32 | Translated physical address, zero on fault |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 30 | Word address |
| mem_wdata | output | 32 | Write data (updated leaf entry) |
| mem_ack | input | 1 | Access completes this cycle; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench goes after the write-back rule from both sides: a first touch must write the leaf, and a repeat touch on an already marked page must not. A design that wrote back unconditionally, or that never set the modified bit on writes, would show a wrong write count or a wrong leaf word in memory. Refused accesses, including the reserved kind and a write to a read-only page that has never been referenced, must leave the leaf untouched. A walker that updated the leaf before checking permission would corrupt it. An invalid directory entry must stop the walk after one read, and a walker that went on to a leaf would show a second read address. The translation at index 1023/1023 with offset 0xFFF catches a slice that is off by one. Memory latencies of zero to two cycles catch a design that fails to hold its request until acknowledged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_DIR    = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_PERM   = 2'd3
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR,
    ST_LEAF,
    ST_WBACK,
    ST_RESP
  } walk_st_e;

  // entry bit positions
  localparam int unsigned EB_VALID = 0;
  localparam int unsigned EB_RD    = 1;
  localparam int unsigned EB_WR    = 2;
  localparam int unsigned EB_EX    = 3;
  localparam int unsigned EB_REF   = 4;
  localparam int unsigned EB_MOD   = 5;

endpackage

// File: rtl/ptw_rst_sync.sv
module ptw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ptw_pte_rules.sv
module ptw_pte_rules
  import ptw_pkg::*;
#(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] ent,
  input  logic [1:0]       acc,
  output logic             allow,
  output logic [ENT_W-1:0] ent_upd,
  output logic             ent_chg
);
  logic [ENT_W-1:0] set_mask;

  always_comb begin
    allow = 1'b0;
    case (acc_e'(acc))
      ACC_READ:  allow = ent[EB_RD];
      ACC_WRITE: allow = ent[EB_WR];
      ACC_EXEC:  allow = ent[EB_EX];
      default:   allow = 1'b0;
    endcase
  end

  always_comb begin
    set_mask = '0;
    set_mask[EB_REF] = 1'b1;
    if (acc_e'(acc) == ACC_WRITE) set_mask[EB_MOD] = 1'b1;
  end

  assign ent_upd = ent | set_mask;
  assign ent_chg = (ent_upd != ent);
endmodule

// File: rtl/ptw_walk.sv
module ptw_walk
  import ptw_pkg::*;
#(
  parameter  int IDX_W   = 10,
  localparam int OFF_W   = IDX_W + 2,
  localparam int VA_W    = 2 * IDX_W + OFF_W,
  localparam int FRAME_W = VA_W - OFF_W,
  localparam int WADDR_W = FRAME_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] root_frame,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [1:0]         req_acc,
  output logic               rsp_valid,
  output logic [1:0]         rsp_fault,
  output logic [VA_W-1:0]    rsp_paddr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [VA_W-1:0]    mem_wdata,
  input  logic               mem_ack,
  input  logic               ent_valid,
  input  logic [FRAME_W-1:0] ent_frame,
  output logic [1:0]         acc_cur,
  input  logic               rule_ok,
  input  logic [VA_W-1:0]    rule_ent,
  input  logic               rule_chg
);
  walk_st_e           state_q, state_d;
  fault_e             fault_q, fault_d;
  logic [VA_W-1:0]    va_q;
  logic [1:0]         acc_q;
  logic [FRAME_W-1:0] tbl_q;
  logic [FRAME_W-1:0] pfn_q;
  logic [VA_W-1:0]    wb_q;

  logic take_en, dir_en, leaf_en;

  assign take_en = (state_q == ST_IDLE) && req_valid;
  assign dir_en  = (state_q == ST_DIR) && mem_ack && ent_valid;
  assign leaf_en = (state_q == ST_LEAF) && mem_ack && ent_valid && rule_ok;

  // next state
  always_comb begin
    state_d = state_q;
    fault_d = fault_q;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          fault_d = FLT_NONE;
          state_d = ST_DIR;
        end
      end
      ST_DIR: begin
        if (mem_ack) begin
          if (!ent_valid) begin
            fault_d = FLT_DIR;
            state_d = ST_RESP;
          end else begin
            state_d = ST_LEAF;
          end
        end
      end
      ST_LEAF: begin
        if (mem_ack) begin
          if (!ent_valid) begin
            fault_d = FLT_ABSENT;
            state_d = ST_RESP;
          end else if (!rule_ok) begin
            fault_d = FLT_PERM;
            state_d = ST_RESP;
          end else if (rule_chg) begin
            state_d = ST_WBACK;
          end else begin
            state_d = ST_RESP;
          end
        end
      end
      ST_WBACK: if (mem_ack) state_d = ST_RESP;
      ST_RESP:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      fault_q <= FLT_NONE;
    end else begin
      state_q <= state_d;
      fault_q <= fault_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (take_en) begin
      va_q  <= req_vaddr;
      acc_q <= req_acc;
    end
    if (dir_en) tbl_q <= ent_frame;
    if (leaf_en) begin
      pfn_q <= ent_frame;
      wb_q  <= rule_ent;
    end
  end

  // outputs
  assign req_ready = (state_q == ST_IDLE);
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_fault = fault_q;
  assign rsp_paddr = (fault_q == FLT_NONE) ? {pfn_q, va_q[OFF_W-1:0]} : '0;
  assign acc_cur   = acc_q;

  assign mem_req   = (state_q == ST_DIR) || (state_q == ST_LEAF) || (state_q == ST_WBACK);
  assign mem_we    = (state_q == ST_WBACK);
  assign mem_wdata = wb_q;

  always_comb begin
    if (state_q == ST_DIR) mem_addr = {root_frame, va_q[VA_W-1 -: IDX_W]};
    else                   mem_addr = {tbl_q, va_q[OFF_W +: IDX_W]};
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top #(
  parameter  int IDX_W   = 10,
  localparam int OFF_W   = IDX_W + 2,
  localparam int VA_W    = 2 * IDX_W + OFF_W,
  localparam int FRAME_W = VA_W - OFF_W,
  localparam int WADDR_W = FRAME_W + IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] root_frame,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic [1:0]         req_acc,
  output logic               rsp_valid,
  output logic [1:0]         rsp_fault,
  output logic [VA_W-1:0]    rsp_paddr,
  output logic               mem_req,
  output logic               mem_we,
  output logic [WADDR_W-1:0] mem_addr,
  output logic [VA_W-1:0]    mem_wdata,
  input  logic               mem_ack,
  input  logic [VA_W-1:0]    mem_rdata
);
  logic            rst_n_int;
  logic [1:0]      acc_cur;
  logic            rule_ok;
  logic            rule_chg;
  logic [VA_W-1:0] rule_ent;

  ptw_rst_sync i_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  ptw_pte_rules #(.ENT_W(VA_W)) i_rules (
    .ent     (mem_rdata),
    .acc     (acc_cur),
    .allow   (rule_ok),
    .ent_upd (rule_ent),
    .ent_chg (rule_chg)
  );

  ptw_walk #(.IDX_W(IDX_W)) i_walk (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .root_frame (root_frame),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_vaddr  (req_vaddr),
    .req_acc    (req_acc),
    .rsp_valid  (rsp_valid),
    .rsp_fault  (rsp_fault),
    .rsp_paddr  (rsp_paddr),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .ent_valid  (mem_rdata[0]),
    .ent_frame  (mem_rdata[VA_W-1:OFF_W]),
    .acc_cur    (acc_cur),
    .rule_ok    (rule_ok),
    .rule_ent   (rule_ent),
    .rule_chg   (rule_chg)
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter  int IDX_W = 10,
  localparam int OFF_W = IDX_W + 2,
  localparam int VA_W  = 2 * IDX_W + OFF_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFF_W-1:0] req_off,
  input logic             rsp_valid,
  input logic [1:0]       rsp_fault,
  input logic [OFF_W-1:0] rsp_off,
  input logic             mem_req,
  input logic             mem_we,
  input logic [VA_W-1:0]  mem_addr_ext,
  input logic [VA_W-1:0]  mem_wdata,
  input logic             mem_ack
);
  logic [OFF_W-1:0] off_seen;
  logic [1:0]       rd_seen;
  logic             wr_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_seen <= '0;
      rd_seen  <= '0;
      wr_seen  <= 1'b0;
    end else if (req_valid && req_ready) begin
      off_seen <= req_off;
      rd_seen  <= '0;
      wr_seen  <= 1'b0;
    end else if (mem_req && mem_ack) begin
      if (mem_we) wr_seen <= 1'b1;
      else        rd_seen <= rd_seen + 2'd1;
    end
  end

  // R10: one translation in flight
  a_r10_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9: response is a single pulse
  a_r9_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11: request held until acknowledged
  a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr_ext)
                               && $stable(mem_wdata)));

  // R7: a write-back always carries valid and referenced set
  a_r7_wb_marks_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[0] && mem_wdata[4]));

  // R3: offset passes through unchanged
  a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd0) |-> (rsp_off == off_seen));

  // R4: directory fault after one read
  a_r4_dir_one_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == 2'd1) |-> (rd_seen == 2'd1 && !wr_seen));

  // R5 / R6: no write-back on any fault
  a_r6_no_wb_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> !wr_seen);
endmodule

bind ptw_top ptw_checker #(.IDX_W(IDX_W)) i_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_off      (req_vaddr[OFF_W-1:0]),
  .rsp_valid    (rsp_valid),
  .rsp_fault    (rsp_fault),
  .rsp_off      (rsp_paddr[OFF_W-1:0]),
  .mem_req      (mem_req),
  .mem_we       (mem_we),
  .mem_addr_ext ({2'b00, mem_addr}),
  .mem_wdata    (mem_wdata),
  .mem_ack      (mem_ack)
);

// File: tb/test_ptw_top.sv
module test_ptw_top;
  localparam logic [19:0] ROOT = 20'h00010;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0]  req_acc = '0;
  logic        req_ready, rsp_valid, mem_req, mem_we;
  logic [1:0]  rsp_fault;
  logic [31:0] rsp_paddr, mem_wdata;
  logic [29:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #2.5 clk = ~clk;

  ptw_top i_ptw_top (
    .clk(clk), .rst_n(rst_n), .root_frame(ROOT),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int total = 0;
  int bad = 0;
  int n_done = 0;
  bit finished = 0;

  // ---------------- memory model
  logic [31:0] mem [logic [29:0]];
  logic [29:0] rd_log [$];
  int rd_cnt = 0, wr_cnt = 0, lat = 0, wait_left = 0;

  function automatic logic [31:0] mrd(logic [29:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      if (wait_left == 0) begin
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata <= mrd(mem_addr);
          rd_log.push_back(mem_addr);
          rd_cnt++;
        end
        wait_left = lat;
      end else begin
        wait_left--;
      end
    end
  end

  // ---------------- checking
  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [1:0]  fault;
    logic [31:0] paddr;
    int          nrd;
    int          nwr;
    logic [29:0] a1;
    logic [29:0] a2;
    bit          leaf_chk;
    logic [31:0] leaf_v;
    string       tag;
  } exp_t;

  exp_t sb [$];

  function automatic exp_t model(logic [31:0] va, logic [1:0] acc, string tag);
    exp_t e;
    logic [31:0] d, l, u;
    bit ok;
    e.tag = tag; e.nwr = 0; e.leaf_chk = 0; e.paddr = '0;
    e.a1 = {ROOT, va[31:22]}; e.a2 = '0;
    d = mrd(e.a1);
    e.nrd = 1;
    if (!d[0]) begin
      e.fault = 2'd1;
      return e;
    end
    e.a2 = {d[31:12], va[21:12]};
    e.nrd = 2;
    l = mrd(e.a2);
    e.leaf_chk = 1; e.leaf_v = l;
    if (!l[0]) begin
      e.fault = 2'd2;
      return e;
    end
    ok = (acc == 2'd0) ? l[1] : (acc == 2'd1) ? l[2] : (acc == 2'd2) ? l[3] : 1'b0;
    if (!ok) begin
      e.fault = 2'd3;
      return e;
    end
    u = l | 32'h10 | ((acc == 2'd1) ? 32'h20 : 32'h0);
    e.fault = 2'd0;
    e.paddr = {l[31:12], va[11:0]};
    e.nwr = (u != l) ? 1 : 0;
    e.leaf_v = u;
    return e;
  endfunction

  // monitor: pops the expected item when the design responds
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      if (sb.size() == 0) begin
        chk(0, "R9 unexpected response", 32'd1, 32'd0);
      end else begin
        e = sb.pop_front();
        chk(rsp_fault == e.fault, {e.tag, " fault"}, 32'(rsp_fault), 32'(e.fault));
        chk(rsp_paddr == e.paddr, "R3 paddr", rsp_paddr, e.paddr);
        chk(rd_cnt == e.nrd, {e.tag, " read count"}, rd_cnt, e.nrd);
        chk(wr_cnt == e.nwr, "R7 write-back count", wr_cnt, e.nwr);
        if (rd_log.size() > 0)
          chk(rd_log[0] == e.a1, "R1 directory addr", 32'(rd_log[0]), 32'(e.a1));
        if (e.nrd == 2 && rd_log.size() > 1)
          chk(rd_log[1] == e.a2, "R2 leaf addr", 32'(rd_log[1]), 32'(e.a2));
        if (e.leaf_chk)
          chk(mrd(e.a2) == e.leaf_v, {e.tag, " leaf word"}, mrd(e.a2), e.leaf_v);
        chk(req_ready == 1'b0, "R10 ready low at response", 32'(req_ready), 32'd0);
      end
      n_done++;
    end
  end

  // driver
  task automatic xlat(logic [9:0] i1, logic [9:0] i2, logic [11:0] off,
                      logic [1:0] acc, int l, string tag);
    int prev;
    logic [31:0] va;
    va = {i1, i2, off};
    @(negedge clk);
    sb.push_back(model(va, acc, tag));
    rd_cnt = 0; wr_cnt = 0; rd_log.delete();
    lat = l; wait_left = l;
    prev = n_done;
    req_vaddr = va; req_acc = acc; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after accept", 32'(req_ready), 32'd0);
    wait (n_done != prev);
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready again when idle", 32'(req_ready), 32'd1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_done, 13);
    summary();
  end

  initial begin
    // directory: idx0 -> frame 0x00020, idx1023 -> frame 0x00030, idx1 invalid
    mem[{ROOT, 10'd0}]    = {20'h00020, 12'h001};
    mem[{ROOT, 10'd1023}] = {20'h00030, 12'h001};
    mem[{ROOT, 10'd1}]    = {20'h00040, 12'h000};
    // leaves in frame 0x00020
    mem[{20'h00020, 10'd5}] = {20'hABCDE, 12'h003}; // V R
    mem[{20'h00020, 10'd6}] = {20'h12345, 12'h007}; // V R W
    mem[{20'h00020, 10'd7}] = {20'h55555, 12'h003}; // V R
    mem[{20'h00020, 10'd8}] = {20'hFFFFF, 12'h03E}; // not valid
    mem[{20'h00020, 10'd9}] = {20'h0BEEF, 12'h019}; // V X ref
    mem[{20'h00030, 10'd1023}] = {20'hFFFFF, 12'h00F}; // V R W X

    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R9 reset no response", 32'(rsp_valid), 32'd0);
    chk(mem_req == 1'b0, "R11 reset no memory request", 32'(mem_req), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    xlat(10'd0, 10'd5, 12'h123, 2'd0, 0, "R7 first read");
    xlat(10'd0, 10'd5, 12'h456, 2'd0, 1, "R7 repeat read no write-back");
    xlat(10'd0, 10'd6, 12'h000, 2'd1, 2, "R8 first write");
    xlat(10'd0, 10'd6, 12'h008, 2'd1, 0, "R8 repeat write");
    xlat(10'd0, 10'd6, 12'h010, 2'd0, 1, "R8 read keeps modified");
    xlat(10'd0, 10'd7, 12'h020, 2'd2, 0, "R6 exec refused");
    xlat(10'd0, 10'd7, 12'h030, 2'd1, 2, "R6 write to read-only");
    xlat(10'd1, 10'd7, 12'h040, 2'd0, 1, "R4 directory invalid");
    xlat(10'd0, 10'd8, 12'h050, 2'd0, 0, "R5 page absent");
    xlat(10'd0, 10'd6, 12'h060, 2'd3, 1, "R6 reserved kind");
    xlat(10'd0, 10'd9, 12'h070, 2'd2, 2, "R7 exec already referenced");
    xlat(10'd1023, 10'd1023, 12'hFFF, 2'd1, 1, "R2 top boundary write");
    xlat(10'd0, 10'd5, 12'h000, 2'd1, 0, "R6 write refused on read page");

    chk(sb.size() == 0, "R9 all responses seen", sb.size(), 0);
    summary();
  end
endmodule